// File: doc/BRIEF.md
# Clock Source Mode Controller

This controller decides which oscillator clocks a small CPU core and manages its two low-power states. An internal ring oscillator runs at all times. An external crystal oscillator can be started, stopped and selected as the CPU clock. Software drives these moves with two write strobes. One carries a main-clock select value and the other an oscillator-stop value. HALT and STOP instruction strobes park the core, and an interrupt request wakes it. The controller also watches a stabilization-done flag from an external oscillation-stabilization counter.

The machine has three run states:

- Ring only: the CPU runs on the ring oscillator and the crystal is stopped.
- Ring with crystal on: the CPU still runs on the ring oscillator, but the crystal is running.
- Crystal: the CPU runs on the crystal.

Each write is checked against the rules for the current state. A write that breaks a rule is dropped and raises a sticky error flag. A registered status bit reports which clock is active one cycle after the selection changes, so software can poll it. Any reset request from any source puts the machine back on the ring-oscillator clock with the crystal running.

Top module: `clk_mode_ctrl`

## Requirements
- R1: Out of reset the outputs are cpu_sel_xtal_o=0, xtal_en_o=1, cpu_clk_en_o=1, clk_stat_o=0 and err_o=0, which is the ring-with-crystal-on state. cpu_sel_xtal_o=1 is only ever driven while xtal_en_o=1.
- R2: In the ring-with-crystal-on state, a select write of value 1 while stab_done_i=1 switches the machine to the crystal state. cpu_sel_xtal_o rises on the same clock edge that samples the write.
- R3: A select write of value 1 is dropped, and err_o rises on the next edge, in either of two cases: stab_done_i=0 in the ring-with-crystal-on state, or the machine is in the ring-only state. The machine never moves directly between the ring-only and crystal states.
- R4: In the crystal state, a select write of value 0 returns the machine to ring-with-crystal-on. cpu_sel_xtal_o falls on that edge and xtal_en_o stays 1.
- R5: A stop write of value 1 enters ring-only (xtal_en_o=0) only from ring-with-crystal-on, and only while clk_stat_o=0. Such a write is dropped with err_o raised in two cases: the machine is in the crystal state, or clk_stat_o is still 1.
- R6: In the ring-only state, a stop write of value 0 restarts the crystal (xtal_en_o=1) and enters ring-with-crystal-on. The CPU clock stays on the ring oscillator.
- R7: A halt_i strobe in any run state drops cpu_clk_en_o to 0 and keeps xtal_en_o and cpu_sel_xtal_o unchanged. Select and stop writes are ignored while halted. irq_i restores cpu_clk_en_o=1 in the same run state.
- R8: A stop_i strobe drives cpu_clk_en_o, xtal_en_o and cpu_sel_xtal_o to 0, and it wins over halt_i in the same cycle. irq_i returns to the same run state. If that state has the crystal running, cpu_sel_xtal_o stays 0 until an edge sees stab_done_i=1.
- R9: Any bit of rst_req_i puts the machine in ring-with-crystal-on on the next edge and leaves it awake. It also clears err_o and clk_stat_o. Bits 0 to 4 stand for the external pin, power-on clear, low-voltage detect, clock monitor and watchdog overflow.
- R10: clk_stat_o equals cpu_sel_xtal_o delayed by one clock cycle.
- R11: err_o stays set until an err_clr_i strobe. If a rule-breaking write arrives in the same cycle as err_clr_i, err_o stays set.
- R12: If a select write and a stop write arrive in the same cycle, only the select write is acted upon.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Controller clock (ring oscillator domain) |
| rst_ni | input | 1 | Asynchronous active-low reset |
| rst_req_i | input | NUM_RST_SRC | Synchronous reset requests, one bit per source |
| sel_wr_i | input | 1 | Main-clock select write strobe |
| sel_val_i | input | 1 | Value written with sel_wr_i (1 = crystal) |
| stop_wr_i | input | 1 | Oscillator-stop write strobe |
| stop_val_i | input | 1 | Value written with stop_wr_i (1 = stop crystal) |
| err_clr_i | input | 1 | Clears the error flag |
| halt_i | input | 1 | HALT instruction strobe |
| stop_i | input | 1 | STOP instruction strobe |
| irq_i | input | 1 | Interrupt request, wakes from HALT or STOP |
| stab_done_i | input | 1 | Crystal stabilization complete |
| cpu_sel_xtal_o | output | 1 | CPU clock select, 1 = crystal |
| xtal_en_o | output | 1 | Crystal oscillator enable |
| cpu_clk_en_o | output | 1 | CPU clock gate enable |
| clk_stat_o | output | 1 | Active-clock status, 1 = crystal |
| err_o | output | 1 | Sticky rule-violation flag |

## Verification
The hardest situation to reach is the one-cycle window after a return from crystal to ring. During that window clk_stat_o still reads 1, so a stop write must be refused even though the run state already allows it. The bench places a stop write in the cycle right after the select-0 write to hit that window.

A second hard case is a wake from STOP into the crystal state while stab_done_i is held low. Here the selection must stay on the ring oscillator for several cycles before the flag is raised.

Simultaneous halt and stop strobes, simultaneous writes, and an error clear that collides with a new violation are each driven once. Each reset source bit is exercised from the ring-only state.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;
  typedef enum logic [1:0] {
    RUN_RING_ONLY = 2'd0,
    RUN_RING_XON  = 2'd1,
    RUN_XTAL      = 2'd2
  } run_e;

  typedef enum logic [1:0] {
    LP_NONE = 2'd0,
    LP_HALT = 2'd1,
    LP_STOP = 2'd2
  } lp_e;
endpackage

// File: rtl/clk_mode_run.sv
module clk_mode_run
  import clk_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_any_i,
  input  logic lp_active_i,
  input  logic sel_wr_i,
  input  logic sel_val_i,
  input  logic stop_wr_i,
  input  logic stop_val_i,
  input  logic stab_done_i,
  input  logic clk_stat_i,
  output run_e run_o,
  output logic bad_wr_o
);
  run_e run_q, run_d;
  logic bad;

  always_comb begin
    run_d = run_q;
    bad   = 1'b0;
    if (!lp_active_i) begin
      if (sel_wr_i) begin
        if (sel_val_i) begin
          if (run_q == RUN_RING_XON) begin
            if (stab_done_i) run_d = RUN_XTAL;
            else             bad   = 1'b1;
          end else if (run_q == RUN_RING_ONLY) begin
            bad = 1'b1;
          end
        end else if (run_q == RUN_XTAL) begin
          run_d = RUN_RING_XON;
        end
      end else if (stop_wr_i) begin
        if (stop_val_i) begin
          if (run_q == RUN_RING_XON) begin
            // status must already show the ring clock
            if (!clk_stat_i) run_d = RUN_RING_ONLY;
            else             bad   = 1'b1;
          end else if (run_q == RUN_XTAL) begin
            bad = 1'b1;
          end
        end else if (run_q == RUN_RING_ONLY) begin
          run_d = RUN_RING_XON;
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        run_q <= RUN_RING_XON;
    else if (rst_any_i) run_q <= RUN_RING_XON;
    else                run_q <= run_d;
  end

  assign run_o    = run_q;
  assign bad_wr_o = bad & ~rst_any_i;

  AST_XTAL_ENTRY_STAB: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == RUN_XTAL && $past(run_q) != RUN_XTAL) |-> $past(stab_done_i && sel_wr_i)); // R2
  AST_NO_SKIP_UP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_q) == RUN_RING_ONLY |-> run_q != RUN_XTAL); // R3
  AST_NO_SKIP_DOWN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(run_q) == RUN_XTAL |-> run_q != RUN_RING_ONLY); // R3
  AST_STOP_XTAL_RULE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_q == RUN_RING_ONLY && $past(run_q) != RUN_RING_ONLY) |-> $past(!clk_stat_i)); // R5
  AST_LP_HOLDS_RUN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_active_i && !rst_any_i) |=> run_q == $past(run_q)); // R7
endmodule

// File: rtl/clk_mode_lp.sv
module clk_mode_lp
  import clk_mode_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_any_i,
  input  logic halt_i,
  input  logic stop_i,
  input  logic irq_i,
  input  logic stab_done_i,
  input  run_e run_i,
  output lp_e  lp_o,
  output logic stab_wait_o
);
  lp_e  lp_q, lp_d;
  logic wait_q, wait_d;
  logic wake_stop;

  assign wake_stop = (lp_q == LP_STOP) && irq_i;

  always_comb begin
    lp_d = lp_q;
    if (lp_q == LP_NONE) begin
      if (stop_i)      lp_d = LP_STOP;
      else if (halt_i) lp_d = LP_HALT;
    end else if (irq_i) begin
      lp_d = LP_NONE;
    end
  end

  // crystal restarts after STOP: hold ring selection until it settles again
  always_comb begin
    wait_d = wait_q;
    if (wake_stop && run_i != RUN_RING_ONLY)  wait_d = 1'b1;
    else if (stab_done_i && lp_q == LP_NONE) wait_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lp_q   <= LP_NONE;
      wait_q <= 1'b0;
    end else if (rst_any_i) begin
      lp_q   <= LP_NONE;
      wait_q <= 1'b0;
    end else begin
      lp_q   <= lp_d;
      wait_q <= wait_d;
    end
  end

  assign lp_o        = lp_q;
  assign stab_wait_o = wait_q;

  AST_STOP_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_q == LP_NONE && stop_i && !rst_any_i) |=> lp_q == LP_STOP); // R8
  AST_SLEEP_UNTIL_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lp_q != LP_NONE && !irq_i && !rst_any_i) |=> lp_q == $past(lp_q)); // R7
endmodule

// File: rtl/clk_mode_flags.sv
module clk_mode_flags (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic rst_any_i,
  input  logic sel_xtal_i,
  input  logic bad_wr_i,
  input  logic err_clr_i,
  output logic clk_stat_o,
  output logic err_o
);
  logic stat_q, err_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= 1'b0;
      err_q  <= 1'b0;
    end else if (rst_any_i) begin
      stat_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      stat_q <= sel_xtal_i;
      if (bad_wr_i)       err_q <= 1'b1;
      else if (err_clr_i) err_q <= 1'b0;
    end
  end

  assign clk_stat_o = stat_q;
  assign err_o      = err_q;

  AST_ERR_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_q && !err_clr_i && !rst_any_i) |=> err_q); // R11
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!err_q && !bad_wr_i) |=> !err_q); // R3
endmodule

// File: rtl/clk_mode_ctrl.sv
module clk_mode_ctrl
  import clk_mode_pkg::*;
#(
  parameter int NUM_RST_SRC = 5
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [NUM_RST_SRC-1:0] rst_req_i,
  input  logic                   sel_wr_i,
  input  logic                   sel_val_i,
  input  logic                   stop_wr_i,
  input  logic                   stop_val_i,
  input  logic                   err_clr_i,
  input  logic                   halt_i,
  input  logic                   stop_i,
  input  logic                   irq_i,
  input  logic                   stab_done_i,
  output logic                   cpu_sel_xtal_o,
  output logic                   xtal_en_o,
  output logic                   cpu_clk_en_o,
  output logic                   clk_stat_o,
  output logic                   err_o
);
  logic rst_any, bad_wr, stab_wait, sel_xtal;
  run_e run;
  lp_e  lp;

  assign rst_any = |rst_req_i;

  clk_mode_run u_run (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_any_i   (rst_any),
    .lp_active_i (lp != LP_NONE),
    .sel_wr_i    (sel_wr_i),
    .sel_val_i   (sel_val_i),
    .stop_wr_i   (stop_wr_i),
    .stop_val_i  (stop_val_i),
    .stab_done_i (stab_done_i),
    .clk_stat_i  (clk_stat_o),
    .run_o       (run),
    .bad_wr_o    (bad_wr)
  );

  clk_mode_lp u_lp (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_any_i   (rst_any),
    .halt_i      (halt_i),
    .stop_i      (stop_i),
    .irq_i       (irq_i),
    .stab_done_i (stab_done_i),
    .run_i       (run),
    .lp_o        (lp),
    .stab_wait_o (stab_wait)
  );

  assign sel_xtal = (run == RUN_XTAL) && (lp != LP_STOP) && !stab_wait;

  clk_mode_flags u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .rst_any_i  (rst_any),
    .sel_xtal_i (sel_xtal),
    .bad_wr_i   (bad_wr),
    .err_clr_i  (err_clr_i),
    .clk_stat_o (clk_stat_o),
    .err_o      (err_o)
  );

  assign cpu_sel_xtal_o = sel_xtal;
  assign xtal_en_o      = (run != RUN_RING_ONLY) && (lp != LP_STOP);
  assign cpu_clk_en_o   = (lp == LP_NONE);

  AST_SEL_NEEDS_OSC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cpu_sel_xtal_o |-> xtal_en_o); // R1
  AST_RESET_TO_RING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_any |=> (!cpu_sel_xtal_o && xtal_en_o && cpu_clk_en_o && !err_o && !clk_stat_o)); // R9
  AST_STAT_LAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_any |=> clk_stat_o == $past(cpu_sel_xtal_o)); // R10
endmodule

// File: tb/clk_mode_ctrl_bench.sv
`timescale 1ns/1ps
module clk_mode_ctrl_bench;
  localparam int NSRC = 5;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic [NSRC-1:0] rst_req = '0;
  logic sel_wr = 0, sel_val = 0, stop_wr = 0, stop_val = 0, err_clr = 0;
  logic halt = 0, stp = 0, irq = 0, stab_done = 0;
  logic sel_x, xen, clken, stat, err;

  int total = 0, bad = 0;
  bit done = 0;
  logic [4:0] exp_q[$];
  string tag_q[$];

  always #2.5 clk_i = ~clk_i;

  clk_mode_ctrl #(.NUM_RST_SRC(NSRC)) u_clk_mode_ctrl (
    .clk_i(clk_i), .rst_ni(rst_ni), .rst_req_i(rst_req),
    .sel_wr_i(sel_wr), .sel_val_i(sel_val), .stop_wr_i(stop_wr), .stop_val_i(stop_val),
    .err_clr_i(err_clr), .halt_i(halt), .stop_i(stp), .irq_i(irq), .stab_done_i(stab_done),
    .cpu_sel_xtal_o(sel_x), .xtal_en_o(xen), .cpu_clk_en_o(clken),
    .clk_stat_o(stat), .err_o(err)
  );

  // expected vector {sel_xtal, xtal_en, clk_en, clk_stat, err}, compared after the next edge
  task automatic step(input logic [4:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk_i);
    sel_wr = 0; stop_wr = 0; err_clr = 0; halt = 0; stp = 0; irq = 0; rst_req = '0;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk_i);
      #1;
      if (exp_q.size() > 0) begin
        logic [4:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        total++;
        if ({sel_x, xen, clken, stat, err} !== e) begin
          bad++;
          $display("FAIL %s: got %b expected %b", t, {sel_x, xen, clken, stat, err}, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    step(5'b01100, "R1 reset state");

    sel_wr = 1; sel_val = 1; step(5'b01101, "R3 select without stab");
    err_clr = 1; step(5'b01100, "R11 clear");
    stab_done = 1; sel_wr = 1; sel_val = 1; step(5'b11100, "R2 to crystal");
    step(5'b11110, "R10 status lag");
    stop_wr = 1; stop_val = 1; step(5'b11111, "R5 stop in crystal");
    err_clr = 1; step(5'b11110, "R11 clear");
    sel_wr = 1; sel_val = 0; step(5'b01110, "R4 back to ring");
    stop_wr = 1; stop_val = 1; step(5'b01101, "R5 status still crystal");
    err_clr = 1; step(5'b01100, "R11 clear");
    stop_wr = 1; stop_val = 1; step(5'b00100, "R5 enter ring only");
    sel_wr = 1; sel_val = 1; step(5'b00101, "R3 select from ring only");
    err_clr = 1; sel_wr = 1; sel_val = 1; step(5'b00101, "R11 set wins");
    err_clr = 1; step(5'b00100, "R11 clear");
    stop_wr = 1; stop_val = 0; step(5'b01100, "R6 restart crystal");

    sel_wr = 1; sel_val = 1; stop_wr = 1; stop_val = 1; step(5'b11100, "R12 select wins");
    step(5'b11110, "R10 status");
    halt = 1; step(5'b11010, "R7 halt");
    sel_wr = 1; sel_val = 0; step(5'b11010, "R7 write ignored in halt");
    irq = 1; step(5'b11110, "R7 wake");
    stp = 1; step(5'b00010, "R8 stop");
    step(5'b00000, "R8 stop status");
    stab_done = 0; irq = 1; step(5'b01100, "R8 wake waits stab");
    step(5'b01100, "R8 still waiting");
    stab_done = 1; step(5'b11100, "R8 stab reselects crystal");
    step(5'b11110, "R10 status");
    halt = 1; stp = 1; step(5'b00010, "R8 stop over halt");
    irq = 1; step(5'b01100, "R8 wake");
    step(5'b11100, "R8 reselect");
    step(5'b11110, "R10 status");
    rst_req[3] = 1; step(5'b01100, "R9 reset from crystal");

    for (int i = 0; i < NSRC; i++) begin
      stop_wr = 1; stop_val = 1; step(5'b00100, "R5 ring only");
      rst_req[i] = 1; step(5'b01100, "R9 reset source");
    end

    stop_wr = 1; stop_val = 1; step(5'b00100, "R5 ring only");
    stp = 1; step(5'b00000, "R8 stop from ring only");
    stab_done = 0; irq = 1; step(5'b00100, "R8 wake to ring only");
    stop_wr = 1; stop_val = 0; step(5'b01100, "R6 restart");
    stp = 1; step(5'b00000, "R8 stop");
    irq = 1; step(5'b01100, "R8 wake to ring xon");
    sel_wr = 1; sel_val = 1; step(5'b01101, "R3 select without stab");

    repeat (2) @(negedge clk_i);
    if (exp_q.size() != 0) begin
      total++; bad++;
      $display("FAIL queue: got %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule